// File: doc/BRIEF.md
# Flash Read Line-Buffer Controller

This block connects a fast 32-bit read bus to a slow flash array that delivers a whole line at a time. A small set of line buffers keeps recently fetched lines. A read whose line is already held finishes in two cycles. A read that misses the buffers fetches the whole line from the array. The length of that fetch is set by a programmable read wait-state count and an optional address-setup cycle. After the fetch, the line is kept in the least recently used buffer. The short bus-to-buffer transfer is therefore decoupled from the long array-to-buffer transfer, and only misses pay the array timing.

Reads in an upper alias of the flash space reach the same flash locations as normal reads. Each such read adds 0 to 31 emulated wait states, and the count is encoded in the address itself. A small configuration port sets the buffer enable, the read wait-state count and the address-setup enable. Changing the buffer enable discards every held line.

Top module: `flash_line_buf`

## Requirements
- R1: With buffers enabled, a read outside the alias window whose line is held raises `bus_ready` in the first cycle after the acceptance edge (one address cycle, one data cycle), and it makes no array request.
- R2: With buffers enabled, a read that misses (address setup off, outside the alias window) raises `bus_ready` in cycle `cfg_rwsc + 2` after the acceptance edge.
- R3: When address setup is enabled, a miss makes its first array request in cycle 2 after acceptance instead of cycle 1, and the whole miss takes one cycle longer.
- R4: With buffers disabled, every read is a miss. It pays the full array timing, and no line is retained.
- R5: An address with bits [31:29] zero and bits [28:24] = E (the window 0x01000000 to 0x1FFFFFFF when E is nonzero) adds E cycles to both hit and miss latency. Bits [23:0] select the flash location in every window, so an alias hits on a line fetched through the normal window.
- R6: The returned data is word `addr[3:2]` (word 0 in line bits [31:0]) of the 128-bit line numbered `addr[23:4]`.
- R7: Four line buffers are kept. A miss with all four full replaces the line accessed least recently, where both hits and fills count as accesses.
- R8: A configuration write that changes the buffer enable invalidates all buffers, so the next read of any line misses.
- R9: Only one read is in flight. `bus_req` is sampled only while the block is idle, and a request raised during a busy read is dropped without a fetch. `bus_ready` is a one-cycle pulse.
- R10: A miss holds `arr_req` for exactly `cfg_rwsc + 1` consecutive cycles, and `arr_line` stays stable the whole time.
- R11: After reset `bus_ready` and `arr_req` are low. The configuration resets to buffers disabled, a wait-state count of all ones and address setup enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_req | input | 1 | Read request, sampled while idle |
| bus_addr | input | 32 | Byte address of the read |
| bus_ready | output | 1 | One-cycle pulse; read data valid |
| bus_rdata | output | 32 | Read data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_buf_en | input | 1 | Line-buffer enable |
| cfg_rwsc | input | 4 | Array read wait states |
| cfg_apc | input | 1 | Address-setup cycle enable |
| arr_req | output | 1 | Array read in progress |
| arr_line | output | 20 | Line number being fetched |
| arr_rdata | input | 128 | Line data from the array, valid while `arr_req` is high |

## Verification
The acceptance edge is cycle 0. `bus_ready` is due in cycle 1 + E for a hit and in cycle 1 + E + setup + `cfg_rwsc` + 1 for a miss. The first array request is due in cycle 1 + setup, and it stays high for `cfg_rwsc` + 1 cycles. The bench counts falling edges after the acceptance edge and reads each output at a falling edge, half a cycle away from any register update. It records the cycle in which `bus_ready` first rises, along with the number and start cycle of the `arr_req` cycles, and compares them with those formulas. A list model of buffer recency gives the expected hit or miss for each read.

// File: rtl/flb_pkg.sv
package flb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_FETCH,
      ST_EMUL,
      ST_RESP
   } flb_state_e;
endpackage

// File: rtl/flb_tag_store.sv
module flb_tag_store #(
   parameter int NUM_BUF = 4,
   parameter int TAG_W   = 20,
   localparam int IDX_W  = $clog2(NUM_BUF)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TAG_W-1:0]   lookup_tag,
   input  logic               flush,
   input  logic               upd_en,
   input  logic               upd_fill,
   input  logic [IDX_W-1:0]   upd_idx,
   input  logic [TAG_W-1:0]   upd_tag,
   output logic               hit,
   output logic [IDX_W-1:0]   hit_idx,
   output logic [NUM_BUF-1:0] hit_vec,
   output logic [IDX_W-1:0]   victim_idx,
   output logic [NUM_BUF-1:0] valid_vec
);
   initial begin
      if (NUM_BUF < 2 || (1 << IDX_W) != NUM_BUF)
         $error("flb_tag_store: NUM_BUF must be a power of two of at least 2");
   end

   logic [TAG_W-1:0] tag_q [NUM_BUF];
   logic [IDX_W-1:0] age_q [NUM_BUF];

   genvar g;
   generate
      for (g = 0; g < NUM_BUF; g++) begin : g_cmp
         assign hit_vec[g] = valid_vec[g] && (tag_q[g] == lookup_tag);
      end
   endgenerate

   assign hit = |hit_vec;

   always_comb begin
      hit_idx = '0;
      for (int i = 0; i < NUM_BUF; i++)
         if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
   end

   always_comb begin
      logic found;
      found      = 1'b0;
      victim_idx = '0;
      for (int i = 0; i < NUM_BUF; i++) begin
         if (!valid_vec[i] && !found) begin
            victim_idx = IDX_W'(i);
            found      = 1'b1;
         end
      end
      if (!found) begin
         for (int i = 0; i < NUM_BUF; i++)
            if (age_q[i] == IDX_W'(NUM_BUF - 1)) victim_idx = IDX_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_vec <= '0;
         for (int i = 0; i < NUM_BUF; i++) begin
            tag_q[i] <= '0;
            age_q[i] <= IDX_W'(i);
         end
      end else if (flush) begin
         valid_vec <= '0;
      end else if (upd_en) begin
         for (int i = 0; i < NUM_BUF; i++) begin
            if (IDX_W'(i) == upd_idx)
               age_q[i] <= '0;
            else if (age_q[i] < age_q[upd_idx])
               age_q[i] <= age_q[i] + 1'b1;
         end
         if (upd_fill) begin
            tag_q[upd_idx]     <= upd_tag;
            valid_vec[upd_idx] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/flb_line_store.sv
module flb_line_store #(
   parameter int NUM_BUF = 4,
   parameter int LINE_W  = 128,
   localparam int IDX_W  = $clog2(NUM_BUF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [LINE_W-1:0] wr_line,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [LINE_W-1:0] rd_line
);
   logic [LINE_W-1:0] line_q [NUM_BUF];

   genvar g;
   generate
      for (g = 0; g < NUM_BUF; g++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               line_q[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
               line_q[g] <= wr_line;
         end
      end
   endgenerate

   assign rd_line = line_q[rd_idx];
endmodule

// File: rtl/flb_ctrl.sv
module flb_ctrl
   import flb_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LOC_W   = 24,
   parameter int WORD_W  = 32,
   parameter int WORDS   = 4,
   parameter int NUM_BUF = 4,
   parameter int RWSC_W  = 4,
   parameter int EWS_W   = 5,
   localparam int LINE_W = WORD_W * WORDS,
   localparam int OFF_W  = $clog2(WORD_W / 8),
   localparam int WSEL_W = $clog2(WORDS),
   localparam int TAG_W  = LOC_W - OFF_W - WSEL_W,
   localparam int IDX_W  = $clog2(NUM_BUF),
   localparam int CNT_W  = (RWSC_W > EWS_W) ? RWSC_W : EWS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              bus_ready,
   output logic [WORD_W-1:0] bus_rdata,
   input  logic              buf_en,
   input  logic [RWSC_W-1:0] rwsc,
   input  logic              apc,
   input  logic              hit,
   input  logic [IDX_W-1:0]  hit_idx,
   input  logic [IDX_W-1:0]  victim_idx,
   input  logic [LINE_W-1:0] hit_line,
   input  logic [LINE_W-1:0] arr_rdata,
   output logic              arr_req,
   output logic [TAG_W-1:0]  arr_line,
   output logic [TAG_W-1:0]  lookup_tag,
   output logic              upd_en,
   output logic              upd_fill,
   output logic [IDX_W-1:0]  upd_idx,
   output logic              fill_wr
);
   initial begin
      if (ADDR_W <= LOC_W + EWS_W)
         $error("flb_ctrl: address too narrow for the alias window");
      if ((1 << WSEL_W) != WORDS || WORD_W % 8 != 0)
         $error("flb_ctrl: WORDS must be a power of two, WORD_W whole bytes");
   end

   flb_state_e          state_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [TAG_W-1:0]    tag_q;
   logic [WSEL_W-1:0]   wsel_q;
   logic [EWS_W-1:0]    ews_q;
   logic [EWS_W-1:0]    ews_in;
   logic [WSEL_W-1:0]   wsel_in;
   logic                use_hit;
   logic                accept;
   logic                fetch_last;
   logic                unused_lsb;

   function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] ln,
                                                   input logic [WSEL_W-1:0] ws);
      return ln[ws*WORD_W +: WORD_W];
   endfunction

   assign unused_lsb = ^bus_addr[OFF_W-1:0];
   assign lookup_tag = bus_addr[LOC_W-1:OFF_W+WSEL_W];
   assign wsel_in    = bus_addr[OFF_W+WSEL_W-1:OFF_W];
   assign ews_in     = (bus_addr[ADDR_W-1:LOC_W+EWS_W] == '0) ?
                       bus_addr[LOC_W+EWS_W-1:LOC_W] : '0;
   assign use_hit    = buf_en && hit;
   assign accept     = (state_q == ST_IDLE) && bus_req;
   assign fetch_last = (state_q == ST_FETCH) && (cnt_q == '0);

   assign bus_ready = (state_q == ST_RESP);
   assign arr_req   = (state_q == ST_FETCH);
   assign arr_line  = tag_q;
   assign upd_en    = (accept && use_hit) || (fetch_last && buf_en);
   assign upd_fill  = (state_q == ST_FETCH);
   assign upd_idx   = (state_q == ST_FETCH) ? victim_idx : hit_idx;
   assign fill_wr   = fetch_last && buf_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         tag_q     <= '0;
         wsel_q    <= '0;
         ews_q     <= '0;
         bus_rdata <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (bus_req) begin
                  tag_q  <= lookup_tag;
                  wsel_q <= wsel_in;
                  ews_q  <= ews_in;
                  if (use_hit) begin
                     bus_rdata <= pick_word(hit_line, wsel_in);
                     if (ews_in == '0) begin
                        state_q <= ST_RESP;
                     end else begin
                        state_q <= ST_EMUL;
                        cnt_q   <= CNT_W'(ews_in);
                     end
                  end else if (apc) begin
                     state_q <= ST_SETUP;
                  end else begin
                     state_q <= ST_FETCH;
                     cnt_q   <= CNT_W'(rwsc);
                  end
               end
            end
            ST_SETUP: begin
               state_q <= ST_FETCH;
               cnt_q   <= CNT_W'(rwsc);
            end
            ST_FETCH: begin
               if (cnt_q == '0) begin
                  bus_rdata <= pick_word(arr_rdata, wsel_q);
                  if (ews_q == '0) begin
                     state_q <= ST_RESP;
                  end else begin
                     state_q <= ST_EMUL;
                     cnt_q   <= CNT_W'(ews_q);
                  end
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_EMUL: begin
               if (cnt_q == CNT_W'(1)) state_q <= ST_RESP;
               else                    cnt_q   <= cnt_q - 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/flash_line_buf.sv
module flash_line_buf #(
   parameter int ADDR_W  = 32,
   parameter int LOC_W   = 24,
   parameter int WORD_W  = 32,
   parameter int WORDS   = 4,
   parameter int NUM_BUF = 4,
   parameter int RWSC_W  = 4,
   parameter int EWS_W   = 5,
   localparam int LINE_W = WORD_W * WORDS,
   localparam int OFF_W  = $clog2(WORD_W / 8),
   localparam int WSEL_W = $clog2(WORDS),
   localparam int TAG_W  = LOC_W - OFF_W - WSEL_W,
   localparam int IDX_W  = $clog2(NUM_BUF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              bus_ready,
   output logic [WORD_W-1:0] bus_rdata,
   input  logic              cfg_we,
   input  logic              cfg_buf_en,
   input  logic [RWSC_W-1:0] cfg_rwsc,
   input  logic              cfg_apc,
   output logic              arr_req,
   output logic [TAG_W-1:0]  arr_line,
   input  logic [LINE_W-1:0] arr_rdata
);
   logic              en_q;
   logic [RWSC_W-1:0] rwsc_q;
   logic              apc_q;
   logic              flush;
   logic              hit;
   logic [IDX_W-1:0]  hit_idx;
   logic [NUM_BUF-1:0] hit_vec;
   logic [NUM_BUF-1:0] valid_vec;
   logic [IDX_W-1:0]  victim_idx;
   logic [TAG_W-1:0]  lookup_tag;
   logic              upd_en;
   logic              upd_fill;
   logic [IDX_W-1:0]  upd_idx;
   logic              fill_wr;
   logic [LINE_W-1:0] hit_line;

   assign flush = cfg_we && (cfg_buf_en != en_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         rwsc_q <= '1;
         apc_q  <= 1'b1;
      end else if (cfg_we) begin
         en_q   <= cfg_buf_en;
         rwsc_q <= cfg_rwsc;
         apc_q  <= cfg_apc;
      end
   end

   flb_tag_store #(.NUM_BUF(NUM_BUF), .TAG_W(TAG_W)) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .lookup_tag (lookup_tag),
      .flush      (flush),
      .upd_en     (upd_en),
      .upd_fill   (upd_fill),
      .upd_idx    (upd_idx),
      .upd_tag    (arr_line),
      .hit        (hit),
      .hit_idx    (hit_idx),
      .hit_vec    (hit_vec),
      .victim_idx (victim_idx),
      .valid_vec  (valid_vec)
   );

   flb_line_store #(.NUM_BUF(NUM_BUF), .LINE_W(LINE_W)) u_lines (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (fill_wr),
      .wr_idx  (victim_idx),
      .wr_line (arr_rdata),
      .rd_idx  (hit_idx),
      .rd_line (hit_line)
   );

   flb_ctrl #(
      .ADDR_W(ADDR_W), .LOC_W(LOC_W), .WORD_W(WORD_W), .WORDS(WORDS),
      .NUM_BUF(NUM_BUF), .RWSC_W(RWSC_W), .EWS_W(EWS_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_req    (bus_req),
      .bus_addr   (bus_addr),
      .bus_ready  (bus_ready),
      .bus_rdata  (bus_rdata),
      .buf_en     (en_q),
      .rwsc       (rwsc_q),
      .apc        (apc_q),
      .hit        (hit),
      .hit_idx    (hit_idx),
      .victim_idx (victim_idx),
      .hit_line   (hit_line),
      .arr_rdata  (arr_rdata),
      .arr_req    (arr_req),
      .arr_line   (arr_line),
      .lookup_tag (lookup_tag),
      .upd_en     (upd_en),
      .upd_fill   (upd_fill),
      .upd_idx    (upd_idx),
      .fill_wr    (fill_wr)
   );
endmodule

// File: rtl/flb_checker.sv
module flb_checker #(
   parameter int NUM_BUF = 4,
   parameter int TAG_W   = 20
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_ready,
   input logic               arr_req,
   input logic [TAG_W-1:0]   arr_line,
   input logic               cfg_we,
   input logic               cfg_buf_en,
   input logic               en_q,
   input logic [NUM_BUF-1:0] valid_vec,
   input logic [NUM_BUF-1:0] hit_vec
);
   assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |=> !bus_ready);

   assert_no_fetch_at_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      arr_req |-> !bus_ready);

   assert_line_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      arr_req |=> (!arr_req || $stable(arr_line)));

   assert_flush_on_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (cfg_buf_en != en_q)) |=> (valid_vec == '0));

   assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   assert_no_fill_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && valid_vec == '0) |=> (valid_vec == '0));
endmodule

bind flash_line_buf flb_checker #(.NUM_BUF(NUM_BUF), .TAG_W(TAG_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_ready  (bus_ready),
   .arr_req    (arr_req),
   .arr_line   (arr_line),
   .cfg_we     (cfg_we),
   .cfg_buf_en (cfg_buf_en),
   .en_q       (en_q),
   .valid_vec  (valid_vec),
   .hit_vec    (hit_vec)
);

// File: tb/tb_flash_line_buf.sv
`timescale 1ns/1ps
module tb_flash_line_buf;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_req = 1'b0;
   logic [31:0]  bus_addr = '0;
   logic         bus_ready;
   logic [31:0]  bus_rdata;
   logic         cfg_we = 1'b0;
   logic         cfg_buf_en = 1'b0;
   logic [3:0]   cfg_rwsc = '0;
   logic         cfg_apc = 1'b0;
   logic         arr_req;
   logic [19:0]  arr_line;
   logic [127:0] arr_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // model state
   bit          m_en = 0;
   int          m_rwsc = 15;
   int          m_apc = 1;
   logic [19:0] m_list [4];
   int          m_cnt = 0;

   always #2 clk = ~clk;

   flash_line_buf dut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_addr(bus_addr),
      .bus_ready(bus_ready), .bus_rdata(bus_rdata), .cfg_we(cfg_we),
      .cfg_buf_en(cfg_buf_en), .cfg_rwsc(cfg_rwsc), .cfg_apc(cfg_apc),
      .arr_req(arr_req), .arr_line(arr_line), .arr_rdata(arr_rdata)
   );

   function automatic logic [31:0] memf(input logic [21:0] wi);
      return ({wi[9:0], wi} * 32'h0001_0003) ^ 32'hC3A5_1E0F;
   endfunction

   always_comb begin
      for (int w = 0; w < 4; w++)
         arr_rdata[w*32 +: 32] = memf({arr_line, 2'(w)});
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // recency list model: index 0 is most recent
   function automatic bit model_access(input logic [19:0] ln);
      int pos = -1;
      for (int i = 0; i < m_cnt; i++) if (m_list[i] == ln) pos = i;
      if (pos >= 0) begin
         for (int i = pos; i > 0; i--) m_list[i] = m_list[i-1];
         m_list[0] = ln;
         return 1;
      end
      if (m_en) begin
         for (int i = 3; i > 0; i--) m_list[i] = m_list[i-1];
         m_list[0] = ln;
         if (m_cnt < 4) m_cnt++;
      end
      return 0;
   endfunction

   task automatic cfg(input bit en, input int rw, input int ap);
      @(negedge clk);
      cfg_we = 1; cfg_buf_en = en; cfg_rwsc = 4'(rw); cfg_apc = ap[0];
      @(negedge clk);
      cfg_we = 0;
      if (en != m_en) m_cnt = 0;
      m_en = en; m_rwsc = rw; m_apc = ap;
   endtask

   function automatic logic [31:0] mk(input int ews, input logic [19:0] ln, input int w);
      return {3'b000, 5'(ews), ln, 2'(w), 2'b00};
   endfunction

   task automatic do_read(input logic [31:0] a, input string tag, input bit stray,
                          input logic [31:0] stray_a);
      logic [19:0] ln = a[23:4];
      int ews = (a[31:29] == 0) ? int'(a[28:24]) : 0;
      bit hit = m_en ? model_access(ln) : 0;
      int exp_lat = 1 + ews + (hit ? 0 : m_apc + m_rwsc + 1);
      int n = 0, nreq = 0, first = 0;
      string lt;
      @(negedge clk);
      bus_req = 1; bus_addr = a;
      @(posedge clk);
      #1 bus_req = 0;
      while (n < 200) begin
         @(negedge clk);
         n++;
         if (stray && n == 1) begin bus_req = 1; bus_addr = stray_a; end
         if (stray && n == 2) bus_req = 0;
         if (arr_req) begin nreq++; if (first == 0) first = n; end
         if (bus_ready) break;
      end
      if (tag != "") lt = tag;
      else if (ews != 0) lt = "R5";
      else if (!m_en) lt = "R4";
      else lt = hit ? "R1" : "R2";
      chk(lt, n, exp_lat);
      chk("R6", int'(bus_rdata), int'(memf({ln, a[3:2]})));
      chk("R10", nreq, hit ? 0 : m_rwsc + 1);
      if (!hit) chk("R3", first, 1 + m_apc);
   endtask

   task automatic rd(input logic [31:0] a, input string tag);
      do_read(a, tag, 0, 32'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [19:0] L [6];
      int rws [3];
      L[0] = 20'h00010; L[1] = 20'h00011; L[2] = 20'h3FF20;
      L[3] = 20'h00400; L[4] = 20'hABCDE; L[5] = 20'h12345;
      rws[0] = 0; rws[1] = 2; rws[2] = 5;
      repeat (3) @(negedge clk);
      chk("R11", int'(bus_ready), 0);
      chk("R11", int'(arr_req), 0);
      rst_n = 1;
      @(negedge clk);
      chk("R11", int'(bus_ready), 0);
      // reset configuration: disabled, 15 wait states, setup on
      rd(mk(0, L[2], 1), "R11");
      rd(mk(0, L[2], 1), "R11");
      for (int ri = 0; ri < 3; ri++) begin
         for (int ap = 0; ap < 2; ap++) begin
            cfg(1, rws[ri], ap);
            for (int w = 0; w < 4; w++) rd(mk(0, L[0], w), "");
            rd(mk(0, L[1], 2), "");
            rd(mk(0, L[2], 3), "");
            rd(mk(0, L[3], 0), "");
            rd(mk(0, L[0], 1), "R7");
            rd(mk(0, L[4], 0), "R7");   // evicts L1
            rd(mk(0, L[1], 1), "R7");   // miss, evicts L2
            rd(mk(0, L[3], 3), "R7");   // hit
            rd(mk(0, L[2], 0), "R7");   // miss, evicts L0
            rd(mk(3, L[3], 2), "");     // alias hit, 3 extra
            rd(mk(31, L[5], 1), "");    // alias miss, 31 extra
            rd(mk(0, L[5], 0), "R5");   // normal window hits aliased fill
            rd(mk(1, L[4], 3), "");
            if (rws[ri] == 5) begin
               do_read(mk(0, L[1], 0), "R9", 1, mk(0, 20'h55555, 0));
               rd(mk(0, 20'h55555, 0), "R9");
            end
            cfg(0, rws[ri], ap);
            rd(mk(0, L[3], 1), "R4");
            rd(mk(0, L[3], 1), "R4");
            rd(mk(2, L[3], 2), "");
            cfg(1, rws[ri], ap);
            rd(mk(0, L[4], 0), "R8");
            rd(mk(0, L[4], 2), "R8");
         end
      end
      cfg(1, 1, 0);
      rd(mk(0, L[0], 0), "R2");
      cfg(1, 1, 0);                // same enable: no flush
      rd(mk(0, L[0], 3), "R8");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule